// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command front end of an asynchronous parallel NOR flash, re-timed into a synchronous clock domain. It samples the active-low chip-enable, write-enable, output-enable and device-reset pins together with an 18-bit address and 16-bit data bus. It recognises write cycles, decodes the command byte of each cycle and keeps track of the read mode. It also sequences program and block-erase operations, which are timed by internal cycle counters. The cell array itself is not part of the block. The block reports the target address and data of the current operation, a status byte, and a record of any operation cut short by the reset pin.

A finite-state machine holds the operating state. The states are: READY (idle, accepting commands), PSETUP (program setup seen), ESETUP (erase setup seen), PRUN (program running), ERUN (erase running), PSUSP (program suspended), ESUSP (erase suspended), ESP_SETUP (program setup inside an erase suspension), ESP_RUN (program running inside an erase suspension), ABORT (shutdown interval after a reset during an operation) and HELD (reset mode).

The transitions are as follows:
- READY goes to PSETUP on 0x40 and to ESETUP on 0x20.
- PSETUP goes to PRUN on the next write.
- ESETUP goes to ERUN on 0xD0. Any other byte sends it back to READY with the erase error set.
- PRUN and ERUN go to READY when their counter reaches zero. On 0xB0 they go to PSUSP or ESUSP.
- PSUSP goes back to PRUN on 0xD0.
- ESUSP goes back to ERUN on 0xD0 and to ESP_SETUP on 0x40.
- ESP_SETUP goes to ESP_RUN on the next write.
- ESP_RUN goes back to ESUSP when its counter reaches zero.
- When the reset pin goes low, any state with an operation pending goes to ABORT. Every other state goes to HELD.
- ABORT goes to READY, or to HELD if the reset pin is still low, when the shutdown count expires.
- HELD goes to READY when the reset pin is released.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write cycle is counted only while chip enable and write enable are both low and output enable is high. A pulse with output enable low has no effect on the read mode.
- R2: The address and data of a write are taken as the values present at the end of the pulse, which is the first rising edge of write enable or chip enable. Values shown earlier in the same pulse are discarded.
- R3: The read_mode encoding is array=0, identifier=1, status=2, query=3. The commands that select them are 0xFF (array), 0x90 (identifier), 0x70 (status) and 0x98 (query). Command 0x50 clears both error bits and leaves the read mode unchanged.
- R4: The status byte layout is as follows. Bit 7 is ready (not busy). Bit 6 is erase suspended. Bit 5 is erase error. Bit 4 is program error. Bit 2 is program suspended. All other bits are 0. Bits 6 and 2 are never set together.
- R5: Writing 0x40 and then a second write starts a program of that address and data. busy stays high for PGM_CYC cycles, and afterwards the status reads 0x80.
- R6: Writing 0x20 and then 0xD0 starts an erase lasting ERS_CYC cycles. Any other confirm byte sets the erase error bit and starts nothing.
- R7: While busy is high, read_mode reports status.
- R8: Writing 0xB0 during a program suspends it. busy drops and bit 2 is set, read commands are still accepted, and 0xD0 resumes the remaining count.
- R9: Writing 0xB0 during an erase suspends it (status 0xC0). A program may then run, with status 0x40 while busy. After that program the erase stays suspended until 0xD0 resumes it to completion.
- R10: Reset low with an operation pending aborts it. busy stays high for the SHUT_CYC-cycle shutdown. abort_flag is set, with abort_block=1 and the erase address for an erase, or abort_block=0 and the word address for a program. The matching error bit is also set.
- R11: After the shutdown, the block reads array mode when reset has been released. If reset is still low it stays in reset mode, not busy and ignoring writes, until release, and then reads array mode.
- R12: After reset the block is in array mode, not busy, with status 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Clock-domain reset, active low |
| ce_n | input | 1 | Chip enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| rp_n | input | 1 | Device reset pin, active low |
| addr | input | AW | Address bus |
| din | input | DW | Data bus into the device |
| read_mode | output | 2 | What a read returns (array/identifier/status/query) |
| busy | output | 1 | Operation or shutdown in progress |
| status | output | 8 | Status byte |
| op_addr | output | AW | Target address of the latest operation |
| op_data | output | DW | Data word of the latest program |
| abort_flag | output | 1 | An operation was cut short by reset |
| abort_block | output | 1 | The aborted operation was an erase |
| abort_addr | output | AW | Word or block address made invalid |

## Verification
The bench builds the block with PGM_CYC=20, ERS_CYC=40 and SHUT_CYC=8. With these values a suspend command, which takes about a dozen sampled cycles to arrive through the synchronisers, still lands inside a running program or erase. They also let the shutdown window be checked just before and just after its edge, and keep nested suspend and program sequences short. The two-stage synchronisers put a fixed three-cycle delay between a pin change and a state change, so each check is placed from that count.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2,
        RM_QUERY  = 2'd3
    } rmode_t;

    typedef enum logic [3:0] {
        ST_READY,
        ST_PSETUP,
        ST_ESETUP,
        ST_PRUN,
        ST_ERUN,
        ST_PSUSP,
        ST_ESUSP,
        ST_ESP_SETUP,
        ST_ESP_RUN,
        ST_ABORT,
        ST_HELD
    } fstate_t;

    localparam logic [7:0] CMD_PROG   = 8'h40;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_CONF   = 8'hD0;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_STAT   = 8'h70;
    localparam logic [7:0] CMD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_CLRST  = 8'h50;

endpackage

// File: rtl/fcc_sync.sv
module fcc_sync #(
    parameter int           W    = 1,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {2{INIT[i]}};
            else        sh <= {sh[0], d[i]};
        end
        assign q[i] = sh[1];
    end
endmodule

// File: rtl/fcc_write_detect.sv
module fcc_write_detect #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_end,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    logic wr_now, wr_prev;

    assign wr_now = !ce_n && !we_n && oe_n;
    assign wr_end = wr_prev && !wr_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_prev <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_prev <= wr_now;
            if (wr_now) begin
                wr_addr <= addr;
                wr_data <= din;
            end
        end
    end
endmodule

// File: rtl/fcc_op_timer.sv
module fcc_op_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          en,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= load_val;
        else if (en && cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int AW       = 18,
    parameter int DW       = 16,
    parameter int PGM_CYC  = 20,
    parameter int ERS_CYC  = 40,
    parameter int SHUT_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          rp_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [1:0]    read_mode,
    output logic          busy,
    output logic [7:0]    status,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          abort_flag,
    output logic          abort_block,
    output logic [AW-1:0] abort_addr
);
    localparam int MAX_A = (PGM_CYC > SHUT_CYC) ? PGM_CYC : SHUT_CYC;
    localparam int MAX_C = (ERS_CYC > MAX_A) ? ERS_CYC : MAX_A;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] PGM_L  = CW'(PGM_CYC);
    localparam logic [CW-1:0] ERS_L  = CW'(ERS_CYC);
    localparam logic [CW-1:0] SHUT_L = CW'(SHUT_CYC);

    // pin synchronisation
    logic [3:0]    s_ctl;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_din;

    fcc_sync #(.W(4), .INIT(4'b1111)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({ce_n, we_n, oe_n, rp_n}), .q(s_ctl)
    );
    fcc_sync #(.W(AW + DW), .INIT('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n),
        .d({addr, din}), .q({s_addr, s_din})
    );

    logic          wr_end;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [7:0]    cmd;

    fcc_write_detect #(.AW(AW), .DW(DW)) u_wdet (
        .clk(clk), .rst_n(rst_n),
        .ce_n(s_ctl[3]), .we_n(s_ctl[2]), .oe_n(s_ctl[1]),
        .addr(s_addr), .din(s_din),
        .wr_end(wr_end), .wr_addr(wr_addr), .wr_data(wr_data)
    );
    assign cmd = wr_data[7:0];

    logic rp_low;
    assign rp_low = !s_ctl[0];

    fstate_t state, nstate;

    // timers: main for program/erase, aux for nested program and shutdown
    logic          m_load, m_en, m_zero;
    logic [CW-1:0] m_val;
    logic          a_load, a_en, a_zero;
    logic [CW-1:0] a_val;

    fcc_op_timer #(.CW(CW)) u_tmr_main (
        .clk(clk), .rst_n(rst_n), .load(m_load), .load_val(m_val),
        .en(m_en), .zero(m_zero)
    );
    fcc_op_timer #(.CW(CW)) u_tmr_aux (
        .clk(clk), .rst_n(rst_n), .load(a_load), .load_val(a_val),
        .en(a_en), .zero(a_zero)
    );

    assign m_en = (state == ST_PRUN) || (state == ST_ERUN);
    assign a_en = (state == ST_ESP_RUN) || (state == ST_ABORT);

    logic pending, ers_pending;
    assign ers_pending = (state == ST_ERUN) || (state == ST_ESUSP) ||
                         (state == ST_ESP_SETUP) || (state == ST_ESP_RUN);
    assign pending     = ers_pending || (state == ST_PRUN) || (state == ST_PSUSP);

    // next-state logic
    always_comb begin
        nstate = state;
        m_load = 1'b0;
        m_val  = PGM_L;
        a_load = 1'b0;
        a_val  = SHUT_L;
        if (rp_low && state != ST_ABORT && state != ST_HELD) begin
            if (pending) begin
                nstate = ST_ABORT;
                a_load = 1'b1;
                a_val  = SHUT_L;
            end else begin
                nstate = ST_HELD;
            end
        end else begin
            unique case (state)
                ST_READY: begin
                    if (wr_end && cmd == CMD_PROG)       nstate = ST_PSETUP;
                    else if (wr_end && cmd == CMD_ERASE) nstate = ST_ESETUP;
                end
                ST_PSETUP: begin
                    if (wr_end) begin
                        nstate = ST_PRUN;
                        m_load = 1'b1;
                        m_val  = PGM_L;
                    end
                end
                ST_ESETUP: begin
                    if (wr_end) begin
                        if (cmd == CMD_CONF) begin
                            nstate = ST_ERUN;
                            m_load = 1'b1;
                            m_val  = ERS_L;
                        end else begin
                            nstate = ST_READY;
                        end
                    end
                end
                ST_PRUN: begin
                    if (m_zero)                         nstate = ST_READY;
                    else if (wr_end && cmd == CMD_SUSP) nstate = ST_PSUSP;
                end
                ST_ERUN: begin
                    if (m_zero)                         nstate = ST_READY;
                    else if (wr_end && cmd == CMD_SUSP) nstate = ST_ESUSP;
                end
                ST_PSUSP: begin
                    if (wr_end && cmd == CMD_CONF) nstate = ST_PRUN;
                end
                ST_ESUSP: begin
                    if (wr_end && cmd == CMD_CONF)      nstate = ST_ERUN;
                    else if (wr_end && cmd == CMD_PROG) nstate = ST_ESP_SETUP;
                end
                ST_ESP_SETUP: begin
                    if (wr_end) begin
                        nstate = ST_ESP_RUN;
                        a_load = 1'b1;
                        a_val  = PGM_L;
                    end
                end
                ST_ESP_RUN: begin
                    if (a_zero) nstate = ST_ESUSP;
                end
                ST_ABORT: begin
                    if (a_zero) nstate = rp_low ? ST_HELD : ST_READY;
                end
                ST_HELD: begin
                    if (!rp_low) nstate = ST_READY;
                end
                default: nstate = ST_READY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READY;
        else        state <= nstate;
    end

    // registered outputs
    rmode_t        rmode;
    logic          err_p, err_e;
    logic [AW-1:0] ers_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rmode       <= RM_ARRAY;
            err_p       <= 1'b0;
            err_e       <= 1'b0;
            op_addr     <= '0;
            op_data     <= '0;
            ers_addr    <= '0;
            abort_flag  <= 1'b0;
            abort_block <= 1'b0;
            abort_addr  <= '0;
        end else begin
            if (nstate == ST_ABORT && state != ST_ABORT) begin
                abort_flag  <= 1'b1;
                abort_block <= ers_pending;
                abort_addr  <= ers_pending ? ers_addr : op_addr;
                if (ers_pending) err_e <= 1'b1;
                else             err_p <= 1'b1;
            end
            if (rp_low) begin
                rmode <= RM_ARRAY;
            end else if (wr_end) begin
                unique case (state)
                    ST_READY, ST_PSUSP, ST_ESUSP: begin
                        case (cmd)
                            CMD_ARRAY: rmode <= RM_ARRAY;
                            CMD_IDENT: rmode <= RM_IDENT;
                            CMD_STAT:  rmode <= RM_STATUS;
                            CMD_QUERY: rmode <= RM_QUERY;
                            CMD_CLRST: begin
                                err_p <= 1'b0;
                                err_e <= 1'b0;
                            end
                            CMD_PROG, CMD_ERASE, CMD_CONF: rmode <= RM_STATUS;
                            default: ;
                        endcase
                    end
                    ST_PSETUP, ST_ESP_SETUP: begin
                        op_addr <= wr_addr;
                        op_data <= wr_data;
                        rmode   <= RM_STATUS;
                        if (state == ST_PSETUP) abort_flag <= 1'b0;
                    end
                    ST_ESETUP: begin
                        rmode <= RM_STATUS;
                        if (cmd == CMD_CONF) begin
                            op_addr    <= wr_addr;
                            op_data    <= wr_data;
                            ers_addr   <= wr_addr;
                            abort_flag <= 1'b0;
                        end else begin
                            err_e <= 1'b1;
                        end
                    end
                    ST_PRUN, ST_ERUN: begin
                        if (cmd == CMD_SUSP) rmode <= RM_STATUS;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy      = (state == ST_PRUN) || (state == ST_ERUN) ||
                       (state == ST_ESP_RUN) || (state == ST_ABORT);
    assign read_mode = busy ? RM_STATUS : rmode;
    assign status    = {!busy,
                        (state == ST_ESUSP) || (state == ST_ESP_SETUP) || (state == ST_ESP_RUN),
                        err_e, err_p, 1'b0,
                        (state == ST_PSUSP), 2'b00};
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    read_mode,
    input logic          busy,
    input logic [7:0]    status,
    input logic [AW-1:0] op_addr,
    input logic          abort_flag
);
    p_busy_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> read_mode == 2'd2);

    p_susp_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[6] && status[2]));

    p_abort_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_flag) |-> busy);

    p_psusp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> !busy);

    p_op_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_addr));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .read_mode(read_mode), .busy(busy),
    .status(status), .op_addr(op_addr), .abort_flag(abort_flag)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int PGM = 20;
    localparam int ERS = 40;
    localparam int SHUT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, rp_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [1:0]    read_mode;
    logic          busy;
    logic [7:0]    status;
    logic [AW-1:0] op_addr, abort_addr;
    logic [DW-1:0] op_data;
    logic          abort_flag, abort_block;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(.AW(AW), .DW(DW), .PGM_CYC(PGM), .ERS_CYC(ERS), .SHUT_CYC(SHUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .rp_n(rp_n),
        .addr(addr), .din(din), .read_mode(read_mode), .busy(busy), .status(status),
        .op_addr(op_addr), .op_data(op_data), .abort_flag(abort_flag),
        .abort_block(abort_block), .abort_addr(abort_addr)
    );

    // {addr[35:18], data[17:2], expected read_mode[1:0]}
    localparam logic [35:0] VEC [7] = '{
        {18'h00000, 16'h0090, 2'd1},
        {18'h00055, 16'h0098, 2'd3},
        {18'h00000, 16'h0070, 2'd2},
        {18'h00000, 16'h00FF, 2'd0},
        {18'h00000, 16'h0050, 2'd0},
        {18'h00000, 16'h0098, 2'd3},
        {18'h00000, 16'h00FF, 2'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe);
        @(negedge clk);
        addr = a; din = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // value changes mid-pulse; the late values must be the ones taken
    task automatic wr_late(input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                           input logic [AW-1:0] a1, input logic [DW-1:0] d1);
        @(negedge clk);
        addr = a0; din = d0; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = a1; din = d1;
        repeat (3) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12 reset state
        chk("R12 read_mode", 32'(read_mode), 32'd0);
        chk("R12 busy", 32'(busy), 32'd0);
        chk("R12 status", 32'(status), 32'h80);

        // R3 read-mode command table
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][35:18], VEC[i][17:2], 1'b1);
            chk("R3 read_mode", 32'(read_mode), 32'(VEC[i][1:0]));
        end

        // R1 pulse with output enable low is not a write
        wr(18'h0, 16'h0090, 1'b0);
        chk("R1 oe low ignored", 32'(read_mode), 32'd0);

        // R5 program, R2 late capture, R7 status while busy
        wr(18'h0, 16'h0040, 1'b1);
        chk("R5 setup status mode", 32'(read_mode), 32'd2);
        wr_late(18'h00111, 16'h1111, 18'h2ABCD, 16'hBEEF);
        chk("R5 busy", 32'(busy), 32'd1);
        chk("R7 status while busy", 32'(read_mode), 32'd2);
        chk("R2 op_addr", 32'(op_addr), 32'h2ABCD);
        chk("R2 op_data", 32'(op_data), 32'hBEEF);
        chk("R4 status busy", 32'(status), 32'h00);
        repeat (PGM + 5) @(negedge clk);
        chk("R5 done busy", 32'(busy), 32'd0);
        chk("R5 done status", 32'(status), 32'h80);

        // R6 erase with bad confirm
        wr(18'h0, 16'h0020, 1'b1);
        wr(18'h01000, 16'h0055, 1'b1);
        chk("R6 bad confirm busy", 32'(busy), 32'd0);
        chk("R6 bad confirm status", 32'(status), 32'hA0);
        wr(18'h0, 16'h0050, 1'b1);
        chk("R3 clear status", 32'(status), 32'h80);

        // R8 program suspend / resume
        wr(18'h0, 16'h0040, 1'b1);
        wr(18'h00200, 16'h5A5A, 1'b1);
        wr(18'h0, 16'h00B0, 1'b1);
        chk("R8 suspended busy", 32'(busy), 32'd0);
        chk("R8 suspended status", 32'(status), 32'h84);
        wr(18'h0, 16'h00FF, 1'b1);
        chk("R8 read in suspend", 32'(read_mode), 32'd0);
        wr(18'h0, 16'h00D0, 1'b1);
        chk("R8 resumed busy", 32'(busy), 32'd1);
        repeat (PGM + 5) @(negedge clk);
        chk("R8 resumed done", 32'(status), 32'h80);

        // R9 erase suspend with nested program
        wr(18'h0, 16'h0020, 1'b1);
        wr(18'h10000, 16'h00D0, 1'b1);
        chk("R6 erase busy", 32'(busy), 32'd1);
        wr(18'h0, 16'h00B0, 1'b1);
        chk("R9 erase suspended", 32'(status), 32'hC0);
        wr(18'h0, 16'h0040, 1'b1);
        wr(18'h00300, 16'h1234, 1'b1);
        chk("R9 nested program status", 32'(status), 32'h40);
        chk("R9 nested op_addr", 32'(op_addr), 32'h00300);
        repeat (PGM + 10) @(negedge clk);
        chk("R9 back to suspend", 32'(status), 32'hC0);
        wr(18'h0, 16'h00D0, 1'b1);
        chk("R9 erase resumed", 32'(busy), 32'd1);
        repeat (ERS + 10) @(negedge clk);
        chk("R9 erase done", 32'(status), 32'h80);

        // R10 / R11 abort of a program, reset released early
        wr(18'h0, 16'h0040, 1'b1);
        wr(18'h00444, 16'h0F0F, 1'b1);
        @(negedge clk);
        rp_n = 1'b0;
        repeat (4) @(negedge clk);
        rp_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 busy in shutdown", 32'(busy), 32'd1);
        repeat (5) @(negedge clk);
        chk("R10 shutdown over", 32'(busy), 32'd0);
        chk("R11 array after abort", 32'(read_mode), 32'd0);
        chk("R10 abort flag", 32'(abort_flag), 32'd1);
        chk("R10 abort word", 32'(abort_block), 32'd0);
        chk("R10 abort addr", 32'(abort_addr), 32'h00444);
        chk("R10 program error", 32'(status), 32'h90);
        wr(18'h0, 16'h0050, 1'b1);

        // R10 / R11 abort of an erase, reset held
        wr(18'h0, 16'h0020, 1'b1);
        wr(18'h20000, 16'h00D0, 1'b1);
        @(negedge clk);
        rp_n = 1'b0;
        repeat (SHUT + 10) @(negedge clk);
        chk("R11 held not busy", 32'(busy), 32'd0);
        chk("R10 erase abort block", 32'(abort_block), 32'd1);
        chk("R10 erase abort addr", 32'(abort_addr), 32'h20000);
        chk("R10 erase error", 32'(status), 32'hA0);
        wr(18'h0, 16'h0090, 1'b1);
        chk("R11 write ignored in reset", 32'(read_mode), 32'd0);
        rp_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 array after release", 32'(read_mode), 32'd0);
        chk("R11 idle after release", 32'(busy), 32'd0);

        finish_run();
    end
endmodule